// File: doc/BRIEF.md
# Flash region lock and NVM-bit manager

This block keeps the protection and configuration bits of an embedded flash array: one lock bit per flash region, a security bit and a small set of general-purpose configuration bits. Software reaches it through a one-cycle command port. Each command names an operation and an argument, which is a page number or a configuration-bit index. Program and full-erase requests are screened against the lock bits. A request that hits a locked region is dropped, and the block raises an interrupt and an error flag.

A region holds 64 pages of 256 bytes, so the region of a page is its page number shifted right by six. A dedicated erase pin is qualified by a hold counter. Once qualified, it wipes all lock bits and configuration bit 0, and it arms the release of the security bit. The security bit drops only when the flash array then reports a completed full erase. The security bit gates two permit outputs, one for the debug port and one for the parallel programming port. Configuration bit 0 drives the brownout-detector enable.

Top module: `flash_guard`

## Requirements
- R1: A program command (op 1) whose page lies in a locked region (region = page >> 6) raises no `prog_go`. One cycle after the command, `status[1]` (lock error) and `irq` are high.
- R2: A program command to an unlocked, in-range region pulses `prog_go` for one cycle, one cycle after the command, with no error bit set.
- R3: A lock command (op 3) sets the lock bit of the region of its page argument. An unlock command (op 4) clears that bit.
- R4: A full-erase command (op 2) pulses `erase_go` one cycle later when no lock bit is set. It is aborted with a lock error when any lock bit is set.
- R5: A secure command (op 5) sets the security bit, and `dbg_allow` and `pp_allow` then go low. No command clears the security bit.
- R6: The security bit clears only on an `erase_done` pulse that follows a qualified erase-pin assertion. An `erase_done` pulse without one leaves the bit set.
- R7: The erase pin is qualified only after it has been high on HOLD_CYCLES consecutive rising edges. A shorter pulse changes no bit.
- R8: While the qualified erase pin stays high, all lock bits and configuration bit 0 are cleared.
- R9: Op 6 sets and op 7 clears the configuration bit indexed by the argument. `bod_en` follows configuration bit 0.
- R10: An unknown op (0), a region index at or above NUM_REGIONS, or a configuration index at or above NUM_GP sets `status[2]` (command error) and changes no bit.
- R11: Every command sets `status[0]` (done) one cycle later. A `status_rd` pulse clears all three status bits.
- R12: After reset, all bits and status are zero, `irq` and `bod_en` are low, and both permit outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Operation code |
| cmd_arg | input | ARG_W | Page number or configuration-bit index |
| status_rd | input | 1 | Status read strobe, clears status |
| erase_pin | input | 1 | Bulk-erase request pin, synchronous |
| erase_done | input | 1 | Full erase completed by the array |
| prog_go | output | 1 | Program request passed to the array |
| erase_go | output | 1 | Full-erase request passed to the array |
| status | output | 3 | {command error, lock error, done} |
| irq | output | 1 | Lock-error interrupt |
| dbg_allow | output | 1 | Debug-port flash access permitted |
| pp_allow | output | 1 | Parallel-programming access permitted |
| bod_en | output | 1 | Brownout-detector enable |

## Verification
The assertions check on every cycle that the security bit rises only after a secure command and falls only after `erase_done`. They also check that configuration bit 0 falls only through a clear command or a qualified erase, that a request pulse always has a matching command behind it, and that qualification implies the pin was held. Only the bench scenarios can show the region arithmetic at page boundaries and the abort decisions for each lock pattern. The same holds for the refusal of a short erase pulse and the full chain of erase pin, full erase, `erase_done` and restored permits.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_WIPE   = 3'd2,
    OP_LOCK   = 3'd3,
    OP_UNLOCK = 3'd4,
    OP_SECURE = 3'd5,
    OP_GP_SET = 3'd6,
    OP_GP_CLR = 3'd7
  } op_e;

  localparam int PAGE_SHIFT = 6;

  function automatic int unsigned region_of(input int unsigned page);
    return page >> PAGE_SHIFT;
  endfunction
endpackage

// File: rtl/fg_erase_qual.sv
module fg_erase_qual #(
  parameter int HOLD_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic erase_pin,
  output logic qual
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!erase_pin) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign qual = erase_pin && (cnt == LIMIT);

  // R7
  qual_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qual |-> $past(erase_pin));
endmodule

// File: rtl/fg_cmd_check.sv
module fg_cmd_check
  import flash_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int NUM_GP      = 2,
  parameter int ARG_W       = 16,
  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int GIDX_W = (NUM_GP > 1) ? $clog2(NUM_GP) : 1
) (
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_op,
  input  logic [ARG_W-1:0]       cmd_arg,
  input  logic [NUM_REGIONS-1:0] locks,
  output logic                   do_prog,
  output logic                   do_wipe,
  output logic                   do_lock,
  output logic                   do_unlock,
  output logic                   do_secure,
  output logic                   do_gp_set,
  output logic                   do_gp_clr,
  output logic                   lock_abort,
  output logic                   bad_cmd,
  output logic [RIDX_W-1:0]      ridx,
  output logic [GIDX_W-1:0]      gidx
);
  int unsigned region_n;
  logic        region_ok, gp_ok, hit_lock;

  always_comb begin
    region_n  = region_of(32'(cmd_arg));
    region_ok = region_n < NUM_REGIONS;
    gp_ok     = 32'(cmd_arg) < NUM_GP;
    ridx      = RIDX_W'(region_n);
    gidx      = GIDX_W'(cmd_arg);
    hit_lock  = region_ok && locks[ridx];

    do_prog = 1'b0; do_wipe = 1'b0; do_lock = 1'b0; do_unlock = 1'b0;
    do_secure = 1'b0; do_gp_set = 1'b0; do_gp_clr = 1'b0;
    lock_abort = 1'b0; bad_cmd = 1'b0;

    if (cmd_valid) begin
      unique case (op_e'(cmd_op))
        OP_PROG: begin
          if (!region_ok)    bad_cmd = 1'b1;
          else if (hit_lock) lock_abort = 1'b1;
          else               do_prog = 1'b1;
        end
        OP_WIPE: begin
          if (|locks) lock_abort = 1'b1;
          else        do_wipe = 1'b1;
        end
        OP_LOCK:   if (region_ok) do_lock = 1'b1;   else bad_cmd = 1'b1;
        OP_UNLOCK: if (region_ok) do_unlock = 1'b1; else bad_cmd = 1'b1;
        OP_SECURE: do_secure = 1'b1;
        OP_GP_SET: if (gp_ok) do_gp_set = 1'b1; else bad_cmd = 1'b1;
        OP_GP_CLR: if (gp_ok) do_gp_clr = 1'b1; else bad_cmd = 1'b1;
        default:   bad_cmd = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fg_nvm_bits.sv
module fg_nvm_bits #(
  parameter int NUM_REGIONS = 8,
  parameter int NUM_GP      = 2,
  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int GIDX_W = (NUM_GP > 1) ? $clog2(NUM_GP) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   do_lock,
  input  logic                   do_unlock,
  input  logic                   do_secure,
  input  logic                   do_gp_set,
  input  logic                   do_gp_clr,
  input  logic [RIDX_W-1:0]      ridx,
  input  logic [GIDX_W-1:0]      gidx,
  input  logic                   qual,
  input  logic                   erase_done,
  output logic [NUM_REGIONS-1:0] locks,
  output logic                   sec,
  output logic [NUM_GP-1:0]      gp
);
  logic armed;
  logic sec_release;

  assign sec_release = erase_done && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locks <= '0;
    end else if (qual) begin
      locks <= '0;
    end else if (do_lock) begin
      locks[ridx] <= 1'b1;
    end else if (do_unlock) begin
      locks[ridx] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec   <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (do_secure)        sec <= 1'b1;
      else if (sec_release) sec <= 1'b0;
      if (qual)            armed <= 1'b1;
      else if (erase_done) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp <= '0;
    end else begin
      if (do_gp_set)      gp[gidx] <= 1'b1;
      else if (do_gp_clr) gp[gidx] <= 1'b0;
      if (qual)           gp[0] <= 1'b0;
    end
  end

  // R6
  sec_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec) |-> $past(erase_done));

  // R8
  gp0_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gp[0]) |-> $past(qual || do_gp_clr));
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int NUM_GP      = 2,
  parameter int ARG_W       = 16,
  parameter int HOLD_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic             status_rd,
  input  logic             erase_pin,
  input  logic             erase_done,
  output logic             prog_go,
  output logic             erase_go,
  output logic [2:0]       status,
  output logic             irq,
  output logic             dbg_allow,
  output logic             pp_allow,
  output logic             bod_en
);
  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int GIDX_W = (NUM_GP > 1) ? $clog2(NUM_GP) : 1;

  logic [NUM_REGIONS-1:0] locks;
  logic [NUM_GP-1:0]      gp;
  logic                   sec, qual;
  logic do_prog, do_wipe, do_lock, do_unlock, do_secure, do_gp_set, do_gp_clr;
  logic lock_abort, bad_cmd;
  logic [RIDX_W-1:0] ridx;
  logic [GIDX_W-1:0] gidx;
  logic st_done, st_lock, st_bad;

  fg_erase_qual #(.HOLD_CYCLES(HOLD_CYCLES)) u_qual (
    .clk(clk), .rst_n(rst_n), .erase_pin(erase_pin), .qual(qual));

  fg_cmd_check #(.NUM_REGIONS(NUM_REGIONS), .NUM_GP(NUM_GP), .ARG_W(ARG_W)) u_check (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg), .locks(locks),
    .do_prog(do_prog), .do_wipe(do_wipe), .do_lock(do_lock), .do_unlock(do_unlock),
    .do_secure(do_secure), .do_gp_set(do_gp_set), .do_gp_clr(do_gp_clr),
    .lock_abort(lock_abort), .bad_cmd(bad_cmd), .ridx(ridx), .gidx(gidx));

  fg_nvm_bits #(.NUM_REGIONS(NUM_REGIONS), .NUM_GP(NUM_GP)) u_bits (
    .clk(clk), .rst_n(rst_n), .do_lock(do_lock), .do_unlock(do_unlock),
    .do_secure(do_secure), .do_gp_set(do_gp_set), .do_gp_clr(do_gp_clr),
    .ridx(ridx), .gidx(gidx), .qual(qual), .erase_done(erase_done),
    .locks(locks), .sec(sec), .gp(gp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_go  <= 1'b0;
      erase_go <= 1'b0;
      st_done  <= 1'b0;
      st_lock  <= 1'b0;
      st_bad   <= 1'b0;
    end else begin
      prog_go  <= do_prog;
      erase_go <= do_wipe;
      if (status_rd) begin
        st_done <= 1'b0;
        st_lock <= 1'b0;
        st_bad  <= 1'b0;
      end
      if (cmd_valid)  st_done <= 1'b1;
      if (lock_abort) st_lock <= 1'b1;
      if (bad_cmd)    st_bad  <= 1'b1;
    end
  end

  assign status    = {st_bad, st_lock, st_done};
  assign irq       = st_lock;
  assign dbg_allow = ~sec;
  assign pp_allow  = ~sec;
  assign bod_en    = gp[0];

  // R5
  sec_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec) |-> $past(cmd_valid && cmd_op == OP_SECURE));

  // R1
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cmd_valid && (cmd_op == OP_PROG || cmd_op == OP_WIPE)));

  // R2
  prog_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> $past(cmd_valid && cmd_op == OP_PROG) && !st_lock);

  // R4
  wipe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> $past(cmd_valid && cmd_op == OP_WIPE && locks == '0));
endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;
  localparam int HOLD = 16;
  localparam int NREG = 8;
  localparam int NGP  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [15:0] cmd_arg = '0;
  logic status_rd = 1'b0, erase_pin = 1'b0, erase_done = 1'b0;
  logic prog_go, erase_go, irq, dbg_allow, pp_allow, bod_en;
  logic [2:0] status;

  always #2.5 clk = ~clk;

  flash_guard #(.NUM_REGIONS(NREG), .NUM_GP(NGP), .ARG_W(16), .HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .status_rd(status_rd), .erase_pin(erase_pin), .erase_done(erase_done),
    .prog_go(prog_go), .erase_go(erase_go), .status(status), .irq(irq),
    .dbg_allow(dbg_allow), .pp_allow(pp_allow), .bod_en(bod_en));

  int n_cmp = 0, n_bad = 0;
  bit m_lock [NREG];
  bit m_sec;
  bit m_gp [NGP];
  logic [5:0] exp_q [$];
  string tag_q [$];
  logic seen = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit any_lock();
    for (int i = 0; i < NREG; i++) if (m_lock[i]) return 1'b1;
    return 1'b0;
  endfunction

  // driver: predicts the outcome, pushes it, drives one command, then reads status
  task automatic send(input logic [2:0] op, input int arg, input string tag);
    int rg = arg / 64;
    bit rok = rg < NREG, gok = arg < NGP;
    bit pg = 0, eg = 0, ab = 0, bd = 0;
    case (op)
      3'd1: if (!rok) bd = 1; else if (m_lock[rg]) ab = 1; else pg = 1;
      3'd2: if (any_lock()) ab = 1; else eg = 1;
      3'd3: if (rok) m_lock[rg] = 1; else bd = 1;
      3'd4: if (rok) m_lock[rg] = 0; else bd = 1;
      3'd5: m_sec = 1;
      3'd6: if (gok) m_gp[arg] = 1; else bd = 1;
      3'd7: if (gok) m_gp[arg] = 0; else bd = 1;
      default: bd = 1;
    endcase
    exp_q.push_back({pg, eg, ab, bd, ab, 1'b1});
    tag_q.push_back(tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg[15:0];
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
  endtask

  always @(posedge clk) seen <= cmd_valid;

  // monitor: compares design results with the queued predictions
  always @(negedge clk) begin
    if (seen && exp_q.size() > 0) begin
      logic [5:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " prog_go"},  prog_go,  e[5]);
      check({t, " erase_go"}, erase_go, e[4]);
      check({t, " status"},   status,   {e[2], e[3], e[0]});
      check({t, " irq"},      irq,      e[1]);
    end
  end

  task automatic hold_pin(input int edges);
    @(negedge clk); erase_pin = 1'b1;
    repeat (edges) @(negedge clk);
    erase_pin = 1'b0;
    if (edges > HOLD) begin
      for (int i = 0; i < NREG; i++) m_lock[i] = 0;
      m_gp[0] = 0;
    end
    @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 status", status, 0);
    check("R12 irq", irq, 0);
    check("R12 dbg_allow", dbg_allow, 1);
    check("R12 pp_allow", pp_allow, 1);
    check("R12 bod_en", bod_en, 0);

    send(3'd1, 5,   "R2 prog region0");
    send(3'd1, 200, "R2 prog region3");
    send(3'd3, 130, "R3 lock region2");
    send(3'd1, 128, "R1 prog first page locked");
    send(3'd1, 191, "R1 prog last page locked");
    send(3'd1, 192, "R1 prog next region free");
    send(3'd1, 127, "R1 prog prior region free");
    send(3'd4, 130, "R3 unlock region2");
    send(3'd1, 150, "R3 prog after unlock");

    send(3'd1, 512, "R10 prog region out of range");
    send(3'd3, 600, "R10 lock out of range");
    send(3'd6, 2,   "R10 gp index out of range");
    send(3'd0, 0,   "R10 unknown op");
    send(3'd1, 511, "R10 last page still accepted");

    send(3'd6, 0, "R9 gp0 set");
    check("R9 bod_en on", bod_en, 1);
    send(3'd6, 1, "R9 gp1 set");
    send(3'd7, 1, "R9 gp1 clear");
    check("R9 bod_en kept", bod_en, 1);

    send(3'd2, 0,   "R4 wipe unlocked");
    send(3'd3, 449, "R3 lock region7");
    send(3'd2, 0,   "R4 wipe blocked");

    send(3'd5, 0, "R5 secure");
    check("R5 dbg_allow", dbg_allow, 0);
    check("R5 pp_allow", pp_allow, 0);
    send(3'd7, 0, "R5 clear cmd leaves security");
    send(3'd6, 0, "R5 gp0 set again");
    check("R5 still secured", dbg_allow, 0);

    pulse_done();
    check("R6 done without erase pin", dbg_allow, 0);

    hold_pin(HOLD - 1);
    check("R7 short pulse bod_en", bod_en, 1);
    send(3'd1, 449, "R7 short pulse keeps lock");

    hold_pin(HOLD + 2);
    check("R8 bod_en cleared", bod_en, 0);
    check("R6 security held before erase", pp_allow, 0);
    send(3'd1, 449, "R8 prog after erase pin");
    send(3'd2, 0,   "R4 wipe after erase pin");
    pulse_done();
    check("R6 dbg_allow restored", dbg_allow, 1);
    check("R6 pp_allow restored", pp_allow, 1);

    send(3'd5, 0, "R5 secure again");
    pulse_done();
    check("R6 second done does not release", dbg_allow, 0);

    repeat (3) @(negedge clk);
    check("R11 queue drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule